// File: doc/BRIEF.md
# Time-Division Eight-Lane Serial Link

This block carries an eight-bit parallel word across a single serial wire by giving each bit its own tick in a repeating eight-tick frame. A free-running three-bit tick counter steers a two-level multiplexer tree at the sending side and a matching two-level demultiplexer tree at the receiving side. Both trees are registered, so the steering bits are delayed by different amounts at each tree level to stay aligned with the data moving through it.

Each receiving lane ends in a retriggerable hold timer. A high sample starts the timer, and the next high sample for that lane reloads it before it runs out, so a steady high bit gives a steady high output. If the samples stop being high, the output falls one frame after the last high one. A pause input freezes the counter, both trees and the timers, and forces the low counter bit to read high. A frame-valid flag rises once the pipeline has delivered one full frame after reset.

One clock cycle is one tick. Bit 0 of `par_in` is the first lane in the frame and bit 7 is the last.

Top module: `tdm_serial_link`

## Requirements
- R1: While `rst_n` is low, `count_o` reads 0, and `ser_line`, `par_out` and `frame_valid` read 0.
- R2: When `pause` is low, `count_o` advances by one on every clock, wrapping from 7 to 0.
- R3: While `pause` is high, `count_o` bit 0 reads 1, the counter holds, and `ser_line`, `par_out` and `frame_valid` hold their values whatever `par_in` does. After `pause` is released, counting resumes from the held value and `par_out` shows no dropout.
- R4: With `par_in` held steady, on each unpaused clock `ser_line` carries `par_in[(count_o - 2) mod 8]`, so each input bit occupies exactly one tick per frame.
- R5: A lane's output goes high 4 ticks after its bit is sampled high. Its hold lasts 8 ticks and is reloaded by each high sample, so a steady high bit gives an output with no gaps.
- R6: The receiving side routes each serial tick to exactly one lane. The other lanes receive low, so a one-hot input word gives a one-hot output word.
- R7: Within 12 ticks of any change to `par_in`, `par_out` equals `par_in` (bit for bit, bit 7 as MSB), and it stays equal while the input holds.
- R8: `frame_valid` is low for the first 11 unpaused ticks after reset. It goes high on the 12th and stays high until the next reset.
- R9: With the input word 8'b10001011 applied from reset, `par_out` reads 8'b10001011 once `frame_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock; one cycle is one tick |
| rst_n | input | 1 | Synchronous active-low reset |
| pause | input | 1 | Freezes the link and forces count bit 0 high |
| par_in | input | 8 | Parallel word to be sent |
| ser_line | output | 1 | Serial time-multiplexed line |
| count_o | output | 3 | Tick counter value |
| par_out | output | 8 | Held parallel word at the receiver |
| frame_valid | output | 1 | High once the first full frame has been received |

## Verification
The bench sweeps all 256 input words. Each check is placed exactly 12 ticks after the word changes, which is the worst-case settling time. A design with one register too many, or with a steering bit misaligned at either tree level, gives wrong or rotated output bits at that point. The bench then checks eight consecutive ticks, where a hold timer that is one tick too short shows up as a gap. It also checks the serial slot order against the counter, so a skew in the sender's steering bits shows up as the wrong bit in a slot. Pause is applied while the input changes underneath it, which catches any stage that keeps running when frozen. The exact tick on which `frame_valid` rises is checked as well.

// File: rtl/tdm_link_pkg.sv
// Package: shared constants for the time-division serial link.
// Assumes the lane count is a power of two and a multiple of the group size.
package tdm_link_pkg;
    localparam int unsigned TDM_LANES = 8;  // lanes carried per frame
    localparam int unsigned TDM_GROUP = 4;  // lanes per first-level selector
    localparam int unsigned TDM_LAT   = 4;  // registers from input to hold timer
endpackage

// File: rtl/tdm_tick_counter.sv
// Module: tdm_tick_counter
// Free-running tick counter; the low bit toggles every tick, and the upper
// bits form divide-by-two stages. Pause freezes the count and forces the
// reported low bit high. Assumes CNT_W >= 1.
module tdm_tick_counter #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pause,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_view
);
    logic [CNT_W-1:0] cnt_q;

    // Purpose: advance the count once per tick unless paused.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!pause) cnt_q <= cnt_q + 1'b1;
    end

    // Purpose: report the count with the tick bit forced high during pause.
    always_comb begin
        cnt_view    = cnt_q;
        cnt_view[0] = cnt_q[0] | pause;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/tdm_mux_tree.sv
// Module: tdm_mux_tree
// Two-level registered selector. Level one picks one lane per group with the
// low count bits; level two picks a group with the high count bits, delayed
// one tick to follow the level-one register. Assumes LANES/GROUP >= 2.
module tdm_mux_tree #(
    parameter int unsigned LANES = 8,
    parameter int unsigned GROUP = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     adv,
    input  logic [LANES-1:0]         data,
    input  logic [$clog2(LANES)-1:0] cnt,
    output logic                     ser
);
    localparam int unsigned NGRP  = LANES / GROUP;
    localparam int unsigned LO_W  = $clog2(GROUP);
    localparam int unsigned HI_W  = $clog2(NGRP);
    localparam int unsigned CNT_W = LO_W + HI_W;

    logic [NGRP-1:0] grp_pick;
    logic [NGRP-1:0] grp_q;
    logic [HI_W-1:0] hi_d;
    logic            ser_q;

    for (genvar g = 0; g < NGRP; g++) begin : g_lvl1
        // Purpose: choose this group's lane from the low count bits.
        always_comb begin
            grp_pick[g] = 1'b0;
            for (int j = 0; j < GROUP; j++) begin
                if (cnt[LO_W-1:0] == LO_W'(j)) grp_pick[g] = data[g*GROUP + j];
            end
        end
    end

    // Purpose: register level one and delay the group select to match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q <= '0;
            hi_d  <= '0;
        end else if (adv) begin
            grp_q <= grp_pick;
            hi_d  <= cnt[CNT_W-1:LO_W];
        end
    end

    // Purpose: level two picks the group and drives the line register.
    always_ff @(posedge clk) begin
        if (!rst_n)   ser_q <= 1'b0;
        else if (adv) ser_q <= grp_q[hi_d];
    end

    assign ser = ser_q;
endmodule

// File: rtl/tdm_demux_tree.sv
// Module: tdm_demux_tree
// Two-level registered distributor. The count is delayed two ticks to line
// up with the serial bit; level one steers by the high bits, level two by
// the low bits delayed one more tick. Unselected outputs read low.
module tdm_demux_tree #(
    parameter int unsigned LANES = 8,
    parameter int unsigned GROUP = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     adv,
    input  logic                     ser,
    input  logic [$clog2(LANES)-1:0] cnt,
    output logic [LANES-1:0]         samp
);
    localparam int unsigned NGRP  = LANES / GROUP;
    localparam int unsigned LO_W  = $clog2(GROUP);
    localparam int unsigned HI_W  = $clog2(NGRP);
    localparam int unsigned CNT_W = LO_W + HI_W;

    logic [CNT_W-1:0] cnt_d1, cnt_d2;
    logic [LO_W-1:0]  lo_d3;
    logic [NGRP-1:0]  br_q;
    logic [LANES-1:0] samp_q;

    // Purpose: delay the count so it names the lane now on the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_d1 <= '0;
            cnt_d2 <= '0;
            lo_d3  <= '0;
        end else if (adv) begin
            cnt_d1 <= cnt;
            cnt_d2 <= cnt_d1;
            lo_d3  <= cnt_d2[LO_W-1:0];
        end
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_lvl1
        // Purpose: steer the serial bit into one branch by the high bits.
        always_ff @(posedge clk) begin
            if (!rst_n)   br_q[g] <= 1'b0;
            else if (adv) br_q[g] <= (cnt_d2[CNT_W-1:LO_W] == HI_W'(g)) ? ser : 1'b0;
        end
        for (genvar j = 0; j < GROUP; j++) begin : g_lvl2
            // Purpose: steer the branch into one lane by the low bits.
            always_ff @(posedge clk) begin
                if (!rst_n)   samp_q[g*GROUP + j] <= 1'b0;
                else if (adv) samp_q[g*GROUP + j] <= (lo_d3 == LO_W'(j)) ? br_q[g] : 1'b0;
            end
        end
    end

    assign samp = samp_q;
endmodule

// File: rtl/tdm_hold_timer.sv
// Module: tdm_hold_timer
// Retriggerable hold: a high sample loads HOLD ticks, the timer then counts
// down, and the output is high while the timer is nonzero. Freezes when adv
// is low. Assumes HOLD equals the frame length so slots reload in time.
module tdm_hold_timer #(
    parameter int unsigned HOLD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic samp,
    output logic held
);
    localparam int unsigned TMR_W = $clog2(HOLD + 1);

    logic [TMR_W-1:0] tmr_q;

    // Purpose: reload on a high sample, otherwise run down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              tmr_q <= '0;
        else if (adv) begin
            if (samp)            tmr_q <= TMR_W'(HOLD);
            else if (tmr_q != 0) tmr_q <= tmr_q - 1'b1;
        end
    end

    assign held = (tmr_q != '0);
endmodule

// File: rtl/tdm_serial_link.sv
// Module: tdm_serial_link (top)
// Sender tree, receiver tree and per-lane hold timers sharing one tick
// counter, plus a flag that rises after the pipeline delivers a full frame.
// Assumes one clock cycle per tick and LANES a power of two.
module tdm_serial_link
    import tdm_link_pkg::*;
#(
    parameter int unsigned LANES = TDM_LANES,
    parameter int unsigned GROUP = TDM_GROUP
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pause,
    input  logic [LANES-1:0]         par_in,
    output logic                     ser_line,
    output logic [$clog2(LANES)-1:0] count_o,
    output logic [LANES-1:0]         par_out,
    output logic                     frame_valid
);
    localparam int unsigned CNT_W  = $clog2(LANES);
    localparam int unsigned FILL   = TDM_LAT + LANES;
    localparam int unsigned FILL_W = $clog2(FILL + 1);

    logic             adv;
    logic [CNT_W-1:0] cnt;
    logic [LANES-1:0] lane_samp;
    logic [FILL_W-1:0] fill_q;

    assign adv = ~pause;

    tdm_tick_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .pause(pause), .cnt(cnt), .cnt_view(count_o)
    );

    tdm_mux_tree #(.LANES(LANES), .GROUP(GROUP)) i_tx (
        .clk(clk), .rst_n(rst_n), .adv(adv), .data(par_in), .cnt(cnt), .ser(ser_line)
    );

    tdm_demux_tree #(.LANES(LANES), .GROUP(GROUP)) i_rx (
        .clk(clk), .rst_n(rst_n), .adv(adv), .ser(ser_line), .cnt(cnt), .samp(lane_samp)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_hold
        tdm_hold_timer #(.HOLD(LANES)) i_hold (
            .clk(clk), .rst_n(rst_n), .adv(adv), .samp(lane_samp[i]), .held(par_out[i])
        );
    end

    // Purpose: count unpaused ticks until one full frame has arrived.
    always_ff @(posedge clk) begin
        if (!rst_n)                        fill_q <= '0;
        else if (adv && fill_q != FILL_W'(FILL)) fill_q <= fill_q + 1'b1;
    end

    assign frame_valid = (fill_q == FILL_W'(FILL));
endmodule

// File: rtl/tdm_link_checker.sv
// Module: tdm_link_checker
// Temporal checks on the link, bound to the top module.
module tdm_link_checker #(
    parameter int unsigned LANES = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     pause,
    input logic [$clog2(LANES)-1:0] count_o,
    input logic [LANES-1:0]         par_out,
    input logic                     frame_valid,
    input logic                     ser_line,
    input logic [LANES-1:0]         lane_samp
);
    // R2: count steps by one on each unpaused tick
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pause |=> (pause || count_o == $past(count_o) + 1'b1));

    // R3: outputs frozen across a paused tick
    assert_pause_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pause |=> ($stable(par_out) && $stable(ser_line) && $stable(frame_valid)));

    // R6: at most one lane receives a sample per tick
    assert_one_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lane_samp));

    // R8: frame valid never falls outside reset
    assert_valid_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> frame_valid);

    // R5: a lane output only rises after a sample for it on the prior tick
    assert_rise_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pause && (lane_samp == '0)) |=> ((par_out & ~$past(par_out)) == '0));
endmodule

bind tdm_serial_link tdm_link_checker #(.LANES(LANES)) i_chk (
    .clk(clk), .rst_n(rst_n), .pause(pause), .count_o(count_o),
    .par_out(par_out), .frame_valid(frame_valid), .ser_line(ser_line),
    .lane_samp(lane_samp)
);

// File: tb/test_tdm_serial_link.sv
module test_tdm_serial_link;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pause = 1'b0;
    logic [7:0] par_in = 8'h00;
    logic       ser_line;
    logic [2:0] count_o;
    logic [7:0] par_out;
    logic       frame_valid;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    tdm_serial_link i_tdm_serial_link (
        .clk(clk), .rst_n(rst_n), .pause(pause), .par_in(par_in),
        .ser_line(ser_line), .count_o(count_o), .par_out(par_out),
        .frame_valid(frame_valid)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [2:0] c0;
        logic       s0;
        logic [7:0] o0;
        logic [2:0] prev;
        string      tag;

        // R1: reset state
        par_in = 8'b10001011;
        repeat (3) @(negedge clk);
        check("R1 count", count_o, 0);
        check("R1 ser", ser_line, 0);
        check("R1 par_out", par_out, 0);
        check("R1 valid", frame_valid, 0);
        rst_n = 1'b1;

        // R8, R2, R9: fill timing from reset
        for (int e = 1; e <= 14; e++) begin
            @(negedge clk);
            check("R2 count from reset", count_o, e % 8);
            check("R8 valid", frame_valid, (e >= 12) ? 1 : 0);
            if (e == 12) check("R9 example word", par_out, 8'b10001011);
        end

        // R7, R5, R4, R6: sweep all words
        for (int p = 0; p < 256; p++) begin
            par_in = 8'(p);
            tag = ($countones(8'(p)) == 1) ? "R6" : "R7";
            repeat (12) @(negedge clk);
            check(tag, par_out, p);
            prev = count_o;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                check("R5 no gap", par_out, p);
                check("R4 slot", ser_line, (p >> ((count_o - 3'd2) & 3'd7)) & 1);
                check("R2 step", count_o, 3'(prev + 3'd1));
                prev = count_o;
            end
        end

        // R3: pause freezes everything
        par_in = 8'b10001011;
        repeat (12) @(negedge clk);
        c0 = count_o;
        s0 = ser_line;
        o0 = par_out;
        pause  = 1'b1;
        par_in = 8'b01110100;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            check("R3 count held", count_o, {c0[2:1], 1'b1});
            check("R3 ser held", ser_line, s0);
            check("R3 out held", par_out, o0);
            check("R3 valid held", frame_valid, 1);
        end
        pause  = 1'b0;
        par_in = 8'b10001011;
        @(negedge clk);
        check("R3 resume count", count_o, 3'(c0 + 3'd1));
        for (int k = 0; k < 12; k++) begin
            check("R3 no dropout", par_out, 8'b10001011);
            @(negedge clk);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule